// File: doc/BRIEF.md
# External Bus Hold Arbiter

This block decides when an outside master may take over the external system bus of a microcontroller. The outside master pulls an active-low hold request. The arbiter samples that request on the bus clock through a synchronizer and lets any bus cycle that is already running finish. If the last access was to the external bus, it then spends one idle cycle. After that it turns off every bus-related output driver and drives an active-low hold acknowledge. When the request returns high, the arbiter releases the acknowledge first and turns the drivers back on one clock later. Only then does normal bus work resume.

The internal side requests a bus cycle with `acc_req`, gives the target class with `acc_ext`, and receives a single-cycle grant on `acc_gnt`. The cycle engine reports a running cycle on `cyc_busy`. Requests that arrive while a hold is being set up or is active are stalled. They are granted in the first normal cycle after the return phase. The hold protocol is active only while the bus-mode bit is 1. With the bit at 0, the request pin is ignored.

Top module: `hold_arb`

## Requirements
- R1: After reset, `hold_ack_n` is 1, `addr_oe`, `data_oe` and `ctrl_oe` are 1, and `acc_gnt` is 0.
- R2: The arbiter sees `hold_req_n` only after it has passed a synchronizer of `SYNC_STAGES` flops (default 2). The request is honoured only after that delay. With the bus quiet and the last access internal, the drivers turn off on the 3rd rising edge after the request is first sampled low, and `hold_ack_n` goes low on the 4th.
- R3: While `cyc_busy` is 1, no hold phase starts, and the drivers and acknowledge stay as they are.
- R4: If the most recent granted access before a hold had `acc_ext` = 1, exactly one idle cycle with the drivers still on is inserted before the drivers turn off. Otherwise no idle cycle is inserted.
- R5: The drivers are off for at least one cycle before `hold_ack_n` falls, and they stay off for the whole time `hold_ack_n` is 0.
- R6: When the synchronized request returns high, `hold_ack_n` rises first. The drivers turn on one cycle later.
- R7: `acc_gnt` is 0 from the start of the hold setup until the return phase is over. An `acc_req` held during that time is granted in the first normal cycle afterwards.
- R8: When `bus_mode` is 0, `hold_req_n` has no effect and `hold_ack_n` stays 1. Clearing `bus_mode` during a hold ends the hold as if the request had been released.
- R9: `acc_gnt` is given only when `cyc_busy` is 0. When a synchronized hold request and `acc_req` meet at a cycle boundary, the hold wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| bus_mode | input | 1 | 1 enables the hold protocol |
| hold_req_n | input | 1 | Asynchronous hold request, active low |
| hold_ack_n | output | 1 | Hold acknowledge, active low |
| acc_req | input | 1 | Internal bus cycle request, held until granted |
| acc_ext | input | 1 | Requested cycle targets the external bus |
| cyc_busy | input | 1 | A granted bus cycle is still running |
| acc_gnt | output | 1 | Request accepted in this cycle |
| addr_oe | output | 1 | Address pin driver enable |
| data_oe | output | 1 | Data pin driver enable |
| ctrl_oe | output | 1 | Chip select, strobe and wait pin driver enable |

## Verification
The bench raises a hold request in the middle of a long bus cycle. A design that does not wait for the cycle boundary would cut the access off by tri-stating the bus. It compares holds that follow an external access with holds that follow an internal one. Getting this wrong either drops the idle cycle or adds one where none is needed, and both show up as a one-cycle shift in the driver enables. Two more cases are checked. The first is a grant request raised during a hold, which must neither leak through nor be lost. The second is the bus-mode bit cleared while the bus is held, which must end the hold and not leave the pins floating.

// File: rtl/hold_arb_pkg.sv
package hold_arb_pkg;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_IDLE   = 3'd1,
        ST_ENTER  = 3'd2,
        ST_HOLD   = 3'd3,
        ST_RETURN = 3'd4
    } hold_state_e;

    typedef struct packed {
        hold_state_e state;
        logic        last_ext;
        logic        ack_n;
        logic        drv_en;
    } hold_regs_t;

endpackage

// File: rtl/hold_arb_sync.sv
module hold_arb_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/hold_arb_fsm.sv
module hold_arb_fsm
    import hold_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_en,
    input  logic hreq,
    input  logic acc_req,
    input  logic acc_ext,
    input  logic cyc_busy,
    output logic acc_gnt,
    output logic ack_n,
    output logic drv_en
);
    hold_regs_t regs_d, regs_q;
    logic       hold_want;

    always_comb begin
        hold_want = mode_en & hreq;
        acc_gnt   = acc_req & (regs_q.state == ST_RUN) & ~cyc_busy & ~hold_want;
        regs_d    = regs_q;
        unique case (regs_q.state)
            ST_RUN: begin
                if (hold_want && !cyc_busy)
                    regs_d.state = regs_q.last_ext ? ST_IDLE : ST_ENTER;
            end
            ST_IDLE:   regs_d.state = ST_ENTER;
            ST_ENTER: begin
                regs_d.state    = hold_want ? ST_HOLD : ST_RETURN;
                regs_d.last_ext = 1'b0;
            end
            ST_HOLD: begin
                if (!hold_want) regs_d.state = ST_RETURN;
            end
            ST_RETURN: regs_d.state = ST_RUN;
            default:   regs_d.state = ST_RETURN;
        endcase
        if (acc_gnt) regs_d.last_ext = acc_ext;
        regs_d.ack_n  = (regs_d.state != ST_HOLD);
        regs_d.drv_en = (regs_d.state == ST_RUN) || (regs_d.state == ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.state    <= ST_RUN;
            regs_q.last_ext <= 1'b0;
            regs_q.ack_n    <= 1'b1;
            regs_q.drv_en   <= 1'b1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ack_n  = regs_q.ack_n;
    assign drv_en = regs_q.drv_en;
endmodule

// File: rtl/hold_arb.sv
module hold_arb #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_mode,
    input  logic hold_req_n,
    output logic hold_ack_n,
    input  logic acc_req,
    input  logic acc_ext,
    input  logic cyc_busy,
    output logic acc_gnt,
    output logic addr_oe,
    output logic data_oe,
    output logic ctrl_oe
);
    logic req_n_sync;
    logic drv_en;

    hold_arb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (hold_req_n),
        .dout  (req_n_sync)
    );

    hold_arb_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_en  (bus_mode),
        .hreq     (~req_n_sync),
        .acc_req  (acc_req),
        .acc_ext  (acc_ext),
        .cyc_busy (cyc_busy),
        .acc_gnt  (acc_gnt),
        .ack_n    (hold_ack_n),
        .drv_en   (drv_en)
    );

    assign addr_oe = drv_en;
    assign data_oe = drv_en;
    assign ctrl_oe = drv_en;
endmodule

// File: rtl/hold_arb_chk.sv
module hold_arb_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_mode,
    input logic hold_req_n,
    input logic hold_ack_n,
    input logic cyc_busy,
    input logic acc_gnt,
    input logic addr_oe,
    input logic data_oe,
    input logic ctrl_oe
);
    // R5
    ack_needs_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_ack_n |-> (!addr_oe && !data_oe && !ctrl_oe));

    // R5
    float_before_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_ack_n) |-> $past(!addr_oe));

    // R6
    ack_first_on_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack_n) |-> !data_oe);

    // R2
    ack_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_ack_n) |-> $past(!hold_req_n, 2));

    // R9
    gnt_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_gnt |-> !cyc_busy);

    // R7
    no_gnt_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_ack_n |-> !acc_gnt);

    // R8
    mode_off_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_mode && hold_ack_n) |=> hold_ack_n);
endmodule

bind hold_arb hold_arb_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_mode   (bus_mode),
    .hold_req_n (hold_req_n),
    .hold_ack_n (hold_ack_n),
    .cyc_busy   (cyc_busy),
    .acc_gnt    (acc_gnt),
    .addr_oe    (addr_oe),
    .data_oe    (data_oe),
    .ctrl_oe    (ctrl_oe)
);

// File: tb/sim_hold_arb.sv
module sim_hold_arb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_mode = 1'b1;
    logic hold_req_n = 1'b1;
    logic acc_req = 1'b0;
    logic acc_ext = 1'b0;
    logic cyc_busy = 1'b0;
    logic hold_ack_n, acc_gnt, addr_oe, data_oe, ctrl_oe;

    int    tests = 0;
    int    fails = 0;
    string tag = "R1";
    int    blen = 2;
    int    busy_left = 0;
    bit    gnt_seen = 0;
    int    cycles = 0;

    // reference model: 0 run, 1 idle, 2 setup, 3 held, 4 return
    int m_s1, m_s2, m_st, m_last;
    bit m_ack, m_oe;

    always #2 clk = ~clk;   // 250 MHz

    hold_arb u0 (
        .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .hold_req_n(hold_req_n),
        .hold_ack_n(hold_ack_n), .acc_req(acc_req), .acc_ext(acc_ext),
        .cyc_busy(cyc_busy), .acc_gnt(acc_gnt), .addr_oe(addr_oe),
        .data_oe(data_oe), .ctrl_oe(ctrl_oe)
    );

    function automatic bit exp_gnt();
        return acc_req && (m_st == 0) && !cyc_busy && !(bus_mode && m_s2 == 0);
    endfunction

    task automatic check(input bit ok, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit want;
        bit g;
        int nx;
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; m_st = 0; m_last = 0; m_ack = 1; m_oe = 1;
        end else begin
            want = bus_mode && (m_s2 == 0);
            g    = exp_gnt();
            nx   = m_st;
            if (m_st == 0 && want && !cyc_busy) nx = m_last ? 1 : 2;
            else if (m_st == 1) nx = 2;
            else if (m_st == 2) begin nx = want ? 3 : 4; m_last = 0; end
            else if (m_st == 3 && !want) nx = 4;
            else if (m_st == 4) nx = 0;
            if (g) m_last = acc_ext;
            m_st  = nx;
            m_ack = (nx != 3);
            m_oe  = (nx <= 1);
            m_s2  = m_s1;
            m_s1  = hold_req_n;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check(hold_ack_n == m_ack, "hold_ack_n", hold_ack_n, m_ack);
            check(addr_oe == m_oe && data_oe == m_oe && ctrl_oe == m_oe, "oe",
                  {addr_oe, data_oe, ctrl_oe}, {3{m_oe}});
            check(acc_gnt == exp_gnt(), "acc_gnt", acc_gnt, exp_gnt());
            if (acc_gnt) gnt_seen = 1;
        end
    end

    // simple cycle engine
    always @(posedge clk) begin
        #1;
        if (gnt_seen) begin
            gnt_seen  = 0;
            acc_req   = 0;
            busy_left = blen;
        end
        if (busy_left > 0) begin
            cyc_busy = 1;
            busy_left--;
        end else begin
            cyc_busy = 0;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            tests++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic access(input bit ext, input int len);
        acc_ext = ext; blen = len; acc_req = 1;
        wait (acc_req == 0);
        step(len + 2);
    endtask

    initial begin
        step(3);
        tag = "R1";
        check(hold_ack_n == 1, "reset ack", hold_ack_n, 1);
        check(addr_oe && data_oe && ctrl_oe, "reset oe", addr_oe, 1);
        check(acc_gnt == 0, "reset gnt", acc_gnt, 0);
        rst_n = 1;
        step(2);

        // R2 and R6: plain hold after an internal access
        access(0, 3);
        tag = "R2";
        hold_req_n = 0;
        step(10);
        check(hold_ack_n == 0, "hold granted", hold_ack_n, 0);
        tag = "R6";
        hold_req_n = 1;
        step(8);
        check(hold_ack_n == 1 && addr_oe == 1, "hold released", addr_oe, 1);

        // R4: idle cycle after external access
        access(1, 2);
        tag = "R4";
        hold_req_n = 0;
        step(10);
        hold_req_n = 1;
        step(8);

        // R3: request during a long cycle
        tag = "R3";
        acc_ext = 0; blen = 8; acc_req = 1;
        wait (acc_req == 0);
        step(2);
        hold_req_n = 0;
        step(4);
        check(hold_ack_n == 1 && addr_oe == 1, "busy cycle kept", addr_oe, 1);
        step(12);
        hold_req_n = 1;
        step(8);

        // R7: stalled internal request
        tag = "R7";
        hold_req_n = 0;
        step(8);
        acc_ext = 1; blen = 2; acc_req = 1;
        step(4);
        check(acc_gnt == 0 && acc_req == 1, "stalled in hold", acc_gnt, 0);
        hold_req_n = 1;
        wait (acc_req == 0);
        check(hold_ack_n == 1 && addr_oe == 1, "granted after return", addr_oe, 1);
        step(6);

        // R8: bus-mode bit off
        tag = "R8";
        bus_mode = 0;
        hold_req_n = 0;
        step(10);
        check(hold_ack_n == 1 && addr_oe == 1, "mode off ignores", hold_ack_n, 1);
        hold_req_n = 1;
        step(4);
        bus_mode = 1;
        hold_req_n = 0;
        step(10);
        bus_mode = 0;
        step(4);
        check(hold_ack_n == 1, "mode cleared ends hold", hold_ack_n, 1);
        hold_req_n = 1;
        step(4);
        bus_mode = 1;
        step(4);

        // R9: hold and access meet at a boundary
        tag = "R9";
        hold_req_n = 0;
        step(2);
        acc_ext = 0; blen = 2; acc_req = 1;
        #0;
        check(acc_gnt == 0, "hold wins", acc_gnt, 0);
        step(10);
        hold_req_n = 1;
        wait (acc_req == 0);
        step(6);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule